// File: doc/BRIEF.md
# Multi-Radix Scanned Seven-Segment Display Driver

This block shows one unsigned value on a bank of eight common-anode seven-segment digits that share a single set of segment lines. A free-running scan counter lights one digit at a time; the upper bits of the counter pick the digit, so each digit owns an equal slot of the scan period. With the default 20-bit counter at a 100 MHz clock, a full pass over the eight digits takes about 10 ms. That is fast enough for the eye to see all digits lit at once.

A two-bit mode input picks how the value is rendered. In binary mode each bit gets its own digit. In decimal mode the value is split into ones, tens and hundreds. In hexadecimal mode it is split into two nibbles. A fourth code blanks the display. Digits that the chosen format does not use stay dark. A three-bit LED code reports the active mode.

At the start of every digit slot a short dark window drives all anodes high. The segment pattern of the previous digit therefore never appears on the next one while the lines settle. The anode, segment and LED outputs all leave flip-flops, so the pins never glitch.

Top module: `radix_scan_display`

## Requirements
- R1: While `rst` is high at a clock edge, all anodes are high (off), all segment lines are high (off) and `led` is 000.
- R2: The outputs are registered. After the n-th clock edge following reset (n = 1, 2, ...), they reflect scan count c = (n-1) mod 2^CNT_W, together with `value` and `mode` as sampled at that edge. The digit index is the top three bits of c. Outside the dark window exactly one anode is low, the one at that index, so digits are visited in the order 0, 1, ..., 7 and then wrap.
- R3: When the low CNT_W-3 bits of c are below 2^GUARD_W (the dark window at the start of each slot), all anodes are high and all segment lines are high.
- R4: When `mode` is 0 (binary), digit i shows glyph 0 or 1 for bit i of `value`. Digit 0 is the rightmost.
- R5: When `mode` is 1 (decimal), digits 0, 1 and 2 show the ones, tens and hundreds of `value`, leading zeros included. Digits 3 to 7 are dark.
- R6: When `mode` is 2 (hexadecimal), digit 0 shows the low nibble and digit 1 the high nibble, using glyphs 0-9 and A-F. Digits 2 to 7 are dark.
- R7: When `mode` is 3, all segment lines are high on every digit.
- R8: `seg_n` is active low, with bit 7 = A, bit 6 = B, ..., bit 1 = G and bit 0 = decimal point. The glyphs for 0-F are the hex bytes 03, 9F, 25, 0D, 99, 49, 41, 1F, 01, 09, 11, C1, 63, 85, 61, 71. A dark digit is FF.
- R9: The decimal point segment (`seg_n[0]`) is always high.
- R10: `led` is 001 for binary, 010 for decimal, 100 for hexadecimal and 000 for mode 3. It has the same one-edge latency as the segments.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| value | input | DATA_W (8) | Value to display |
| mode | input | 2 | 0 binary, 1 decimal, 2 hexadecimal, 3 blank |
| anode_n | output | NUM_DIGITS (8) | Active-low digit enables, bit i = digit i |
| seg_n | output | 8 | Active-low segments A..G, decimal point |
| led | output | 3 | One-hot mode indicator |

## Verification
The assertions check on every cycle that at most one anode is low, that a dark bank also has dark segments, and that the decimal point stays off. They also check that the LED code is one-hot or zero, that mode 3 yields blank segments one edge later, and that the scan index only steps by one, opening a dark window each time it moves. Whether each digit shows the right glyph for its radix can only come from the bench scenarios. This covers the decimal split of values such as 0, 9, 100 and 255, nibble order, bit order, blanking of unused digits and exact scan-slot timing. The bench compares every cycle against a model built from the requirements.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

    typedef enum logic [1:0] {
        MODE_BIN = 2'd0,
        MODE_DEC = 2'd1,
        MODE_HEX = 2'd2,
        MODE_OFF = 2'd3
    } disp_mode_e;

    // one character to show on the active digit
    typedef struct packed {
        logic       blank;
        logic [3:0] code;
    } glyph_t;

    localparam int SEG_W = 8;
    localparam int LED_W = 3;

endpackage

// File: rtl/rsd_scan_timer.sv
module rsd_scan_timer #(
    parameter int CNT_W      = 20,
    parameter int NUM_DIGITS = 8,
    parameter int GUARD_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    output logic [$clog2(NUM_DIGITS)-1:0] idx,
    output logic                          guard
);
    localparam int SEL_W  = $clog2(NUM_DIGITS);
    localparam int SLOT_W = CNT_W - SEL_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } scan_t;

    scan_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign idx = s_q.cnt[CNT_W-1 -: SEL_W];

    generate
        if (GUARD_W >= SLOT_W) begin : g_all_guard
            assign guard = 1'b1;
        end else begin : g_guard
            assign guard = ~|s_q.cnt[SLOT_W-1:GUARD_W];
        end
    endgenerate

    // R2: the digit index only moves forward by one position
    a_r2_idx_step: assert property (@(posedge clk) disable iff (rst)
        (idx != $past(idx)) |-> (idx == SEL_W'($past(idx) + 1'b1)));

    // R3: every new slot begins inside the dark window
    a_r3_guard_on_change: assert property (@(posedge clk) disable iff (rst)
        (idx != $past(idx)) |-> guard);

endmodule

// File: rtl/rsd_digit_extract.sv
module rsd_digit_extract
    import rsd_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int NUM_DIGITS = 8
) (
    input  logic [DATA_W-1:0]             value,
    input  disp_mode_e                    mode,
    input  logic [$clog2(NUM_DIGITS)-1:0] idx,
    output glyph_t                        glyph
);
    localparam int SEL_W      = $clog2(NUM_DIGITS);
    localparam int DEC_RAW    = (DATA_W * 301 + 999) / 1000;
    localparam int DEC_DIGITS = (DEC_RAW < 1) ? 1 : DEC_RAW;
    localparam int HEX_DIGITS = (DATA_W + 3) / 4;
    localparam int BIN_SHOWN  = (DATA_W < NUM_DIGITS) ? DATA_W : NUM_DIGITS;
    localparam int DEC_SHOWN  = (DEC_DIGITS < NUM_DIGITS) ? DEC_DIGITS : NUM_DIGITS;
    localparam int HEX_SHOWN  = (HEX_DIGITS < NUM_DIGITS) ? HEX_DIGITS : NUM_DIGITS;
    localparam int BCD_W      = 4 * DEC_DIGITS;
    localparam int HPAD_W     = 4 * HEX_DIGITS;

    // shift-and-add-three conversion to packed decimal
    function automatic logic [BCD_W-1:0] to_bcd(input logic [DATA_W-1:0] v);
        logic [BCD_W-1:0] b;
        b = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            for (int d = 0; d < DEC_DIGITS; d++) begin
                if (b[4*d +: 4] >= 4'd5) b[4*d +: 4] = b[4*d +: 4] + 4'd3;
            end
            b = {b[BCD_W-2:0], v[i]};
        end
        return b;
    endfunction

    logic [BCD_W-1:0]  bcd;
    logic [HPAD_W-1:0] hex_pad;

    assign bcd     = to_bcd(value);
    assign hex_pad = HPAD_W'(value);

    always_comb begin
        glyph.blank = 1'b1;
        glyph.code  = 4'd0;
        unique case (mode)
            MODE_BIN: begin
                for (int i = 0; i < BIN_SHOWN; i++) begin
                    if (idx == SEL_W'(i)) begin
                        glyph.blank = 1'b0;
                        glyph.code  = {3'b000, value[i]};
                    end
                end
            end
            MODE_DEC: begin
                for (int i = 0; i < DEC_SHOWN; i++) begin
                    if (idx == SEL_W'(i)) begin
                        glyph.blank = 1'b0;
                        glyph.code  = bcd[4*i +: 4];
                    end
                end
            end
            MODE_HEX: begin
                for (int i = 0; i < HEX_SHOWN; i++) begin
                    if (idx == SEL_W'(i)) begin
                        glyph.blank = 1'b0;
                        glyph.code  = hex_pad[4*i +: 4];
                    end
                end
            end
            default: begin
                glyph.blank = 1'b1;
                glyph.code  = 4'd0;
            end
        endcase
    end

endmodule

// File: rtl/rsd_glyph_encoder.sv
module rsd_glyph_encoder
    import rsd_pkg::*;
(
    input  glyph_t           glyph,
    output logic [SEG_W-1:0] seg_n
);
    logic [6:0] lit; // A..G, active high

    always_comb begin
        unique case (glyph.code)
            4'h0: lit = 7'b1111110;
            4'h1: lit = 7'b0110000;
            4'h2: lit = 7'b1101101;
            4'h3: lit = 7'b1111001;
            4'h4: lit = 7'b0110011;
            4'h5: lit = 7'b1011011;
            4'h6: lit = 7'b1011111;
            4'h7: lit = 7'b1110000;
            4'h8: lit = 7'b1111111;
            4'h9: lit = 7'b1111011;
            4'hA: lit = 7'b1110111;
            4'hB: lit = 7'b0011111;
            4'hC: lit = 7'b1001110;
            4'hD: lit = 7'b0111101;
            4'hE: lit = 7'b1001111;
            default: lit = 7'b1000111;
        endcase
        // decimal point never lit
        seg_n = glyph.blank ? {SEG_W{1'b1}} : ~{lit, 1'b0};
    end

endmodule

// File: rtl/radix_scan_display.sv
module radix_scan_display
    import rsd_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int NUM_DIGITS = 8,
    parameter int CNT_W      = 20,
    parameter int GUARD_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DATA_W-1:0]     value,
    input  logic [1:0]            mode,
    output logic [NUM_DIGITS-1:0] anode_n,
    output logic [SEG_W-1:0]      seg_n,
    output logic [LED_W-1:0]      led
);
    localparam int SEL_W = $clog2(NUM_DIGITS);

    typedef struct packed {
        logic [NUM_DIGITS-1:0] anode_n;
        logic [SEG_W-1:0]      seg_n;
        logic [LED_W-1:0]      led;
    } out_t;

    out_t             o_d, o_q;
    logic [SEL_W-1:0] idx;
    logic             guard;
    disp_mode_e       mode_e;
    glyph_t           glyph;
    logic [SEG_W-1:0] glyph_seg_n;
    logic [NUM_DIGITS-1:0] sel_n;

    assign mode_e = disp_mode_e'(mode);

    rsd_scan_timer #(
        .CNT_W      (CNT_W),
        .NUM_DIGITS (NUM_DIGITS),
        .GUARD_W    (GUARD_W)
    ) u_scan (
        .clk   (clk),
        .rst   (rst),
        .idx   (idx),
        .guard (guard)
    );

    rsd_digit_extract #(
        .DATA_W     (DATA_W),
        .NUM_DIGITS (NUM_DIGITS)
    ) u_extract (
        .value (value),
        .mode  (mode_e),
        .idx   (idx),
        .glyph (glyph)
    );

    rsd_glyph_encoder u_encode (
        .glyph (glyph),
        .seg_n (glyph_seg_n)
    );

    generate
        for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_sel
            assign sel_n[k] = (idx != SEL_W'(k));
        end
    endgenerate

    always_comb begin
        o_d = o_q;
        if (guard) begin
            o_d.anode_n = '1;
            o_d.seg_n   = '1;
        end else begin
            o_d.anode_n = sel_n;
            o_d.seg_n   = glyph_seg_n;
        end
        unique case (mode_e)
            MODE_BIN: o_d.led = 3'b001;
            MODE_DEC: o_d.led = 3'b010;
            MODE_HEX: o_d.led = 3'b100;
            default:  o_d.led = 3'b000;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q.anode_n <= '1;
            o_q.seg_n   <= '1;
            o_q.led     <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign anode_n = o_q.anode_n;
    assign seg_n   = o_q.seg_n;
    assign led     = o_q.led;

    // R2: never more than one digit enabled
    a_r2_single_anode: assert property (@(posedge clk) disable iff (rst)
        $countones(~anode_n) <= 1);

    // R3: with no digit enabled the segment lines are dark too
    a_r3_dark_bank: assert property (@(posedge clk) disable iff (rst)
        (anode_n == '1) |-> (seg_n == '1));

    // R9: decimal point stays off
    a_r9_dp_off: assert property (@(posedge clk) disable iff (rst)
        seg_n[0] == 1'b1);

    // R7: blank mode darkens all segments one edge later
    a_r7_blank_mode: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3) |=> (seg_n == '1));

    // R10: mode indicator is one-hot or zero
    a_r10_led_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(led));

endmodule

// File: tb/sim_radix_scan_display.sv
module sim_radix_scan_display;

    localparam int DATA_W  = 8;
    localparam int NDIG    = 8;
    localparam int CNT_W   = 8;
    localparam int GUARD_W = 2;
    localparam int SLOT_W  = CNT_W - 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DATA_W-1:0] value = '0;
    logic [1:0]       mode = 2'd0;
    logic [NDIG-1:0]  anode_n;
    logic [7:0]       seg_n;
    logic [2:0]       led;

    int vectors = 0;
    int fails   = 0;
    int n       = 0;
    int cyc     = 0;
    logic armed = 1'b0;
    logic seen_rst = 1'b1;
    logic [DATA_W-1:0] seen_v = '0;
    logic [1:0] seen_m = '0;

    always #4 clk = ~clk;

    radix_scan_display #(
        .DATA_W     (DATA_W),
        .NUM_DIGITS (NDIG),
        .CNT_W      (CNT_W),
        .GUARD_W    (GUARD_W)
    ) u0 (
        .clk     (clk),
        .rst     (rst),
        .value   (value),
        .mode    (mode),
        .anode_n (anode_n),
        .seg_n   (seg_n),
        .led     (led)
    );

    // R8 glyph bytes, active low, A at bit 7, DP at bit 0
    function automatic logic [7:0] glyph_byte(input int d);
        case (d)
            0: return 8'h03;  1: return 8'h9F;  2: return 8'h25;  3: return 8'h0D;
            4: return 8'h99;  5: return 8'h49;  6: return 8'h41;  7: return 8'h1F;
            8: return 8'h01;  9: return 8'h09;  10: return 8'h11; 11: return 8'hC1;
            12: return 8'h63; 13: return 8'h85; 14: return 8'h61; default: return 8'h71;
        endcase
    endfunction

    function automatic logic [7:0] exp_seg(input int v, input int m, input int dig);
        case (m)
            0: return glyph_byte((v >> dig) & 1);
            1: begin
                if (dig == 0) return glyph_byte(v % 10);
                if (dig == 1) return glyph_byte((v / 10) % 10);
                if (dig == 2) return glyph_byte(v / 100);
                return 8'hFF;
            end
            2: begin
                if (dig == 0) return glyph_byte(v & 15);
                if (dig == 1) return glyph_byte((v >> 4) & 15);
                return 8'hFF;
            end
            default: return 8'hFF;
        endcase
    endfunction

    function automatic string mode_tag(input int m);
        case (m)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk) begin
        armed    <= 1'b1;
        seen_rst <= rst;
        seen_v   <= value;
        seen_m   <= mode;
        if (rst) n <= 0;
        else     n <= n + 1;
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, actual cyc=%0d expected < 150000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // cycle-accurate comparison on the falling edge
    always @(negedge clk) begin
        if (armed) begin
            logic [NDIG-1:0] ea;
            logic [7:0] es;
            logic [2:0] el;
            int c, dig, off;
            vectors = vectors + 1;
            if (seen_rst) begin
                if (anode_n !== 8'hFF || seg_n !== 8'hFF || led !== 3'b000) begin
                    fails = fails + 1;
                    $display("FAIL R1 reset: actual an=%h seg=%h led=%b expected an=ff seg=ff led=000",
                             anode_n, seg_n, led);
                end
            end else begin
                c   = (n - 1) % (1 << CNT_W);
                dig = c >> SLOT_W;
                off = c & ((1 << SLOT_W) - 1);
                if (off < (1 << GUARD_W)) begin
                    ea = '1;
                    es = 8'hFF;
                end else begin
                    ea = ~(NDIG'(1) << dig);
                    es = exp_seg(int'(seen_v), int'(seen_m), dig);
                end
                case (seen_m)
                    2'd0: el = 3'b001;
                    2'd1: el = 3'b010;
                    2'd2: el = 3'b100;
                    default: el = 3'b000;
                endcase
                if (anode_n !== ea) begin
                    fails = fails + 1;
                    $display("FAIL R2 R3 anode c=%0d: actual %b expected %b", c, anode_n, ea);
                end
                if (seg_n !== es) begin
                    fails = fails + 1;
                    $display("FAIL %s R8 seg v=%0d dig=%0d off=%0d: actual %h expected %h",
                             mode_tag(int'(seen_m)), seen_v, dig, off, seg_n, es);
                end
                if (seg_n[0] !== 1'b1) begin
                    fails = fails + 1;
                    $display("FAIL R9 decimal point: actual %b expected 1", seg_n[0]);
                end
                if (led !== el) begin
                    fails = fails + 1;
                    $display("FAIL R10 led: actual %b expected %b", led, el);
                end
            end
        end
    end

    task automatic apply(input int v, input int m, input int hold);
        @(posedge clk);
        #2;
        value = DATA_W'(v);
        mode  = 2'(m);
        repeat (hold) @(posedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        // directed corners: R4 bit order, R5 decimal split, R6 nibbles, R7 blank
        apply(8'hA5, 0, 300);
        apply(0,     0, 280);
        apply(255,   1, 300);
        apply(0,     1, 280);
        apply(100,   1, 280);
        apply(9,     1, 280);
        apply(8'hF0, 2, 280);
        apply(8'h3C, 2, 280);
        apply(255,   3, 280);
        // mid-run reset, R1
        @(posedge clk);
        #2 rst = 1'b1;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // random mix, including short holds that change inside a slot
        for (int k = 0; k < 80; k++) begin
            apply(int'($urandom % 256), int'($urandom % 4), 1 + int'($urandom % 500));
        end
        repeat (4) @(posedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule